// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Front End

This block sits between a simple memory-mapped register bus and the bit-level engine of an I2C master. Software drives all traffic through one data/command register: each write queues either a byte to send or a request to read one byte, and each read takes the oldest byte the engine has received. Queued commands go to the engine in order through a valid/take handshake. Bytes the engine receives come back through a one-cycle push.

Every read request reserves a slot in the receive queue at the moment it is queued. As a result the engine can never return more bytes than the receive queue can hold. Software can read both queue fill levels and both queue depths. A transmit-empty output tells an interrupt controller when the command queue has drained to a programmable low-water mark. A single enable bit gates the whole path. Clearing it empties both queues at once.

Top module: `i2cq_ctrl`

## Requirements
- R1: A bus write to offset 0x10 with bit 8 clear queues bits 7:0 as a transmit byte, and bits 31:9 are ignored. Queued commands reach `eng_cmd_data` in the order they were written, with `eng_cmd_rd` low.
- R2: A bus write to offset 0x10 with bit 8 set queues a read request, which is presented with `eng_cmd_rd` high.
- R3: A bus read of offset 0x10 returns the oldest received byte in bits 7:0, with zeros above, and removes that byte from the receive queue.
- R4: Offset 0x74 returns the command queue level and offset 0x78 returns the receive queue level. Both are 0 after reset, and each takes its new value on the clock edge that ends the access or handshake that changed it.
- R5: Offset 0xF4 returns the command queue depth minus one in bits 23:16 and the receive queue depth minus one in bits 15:8. All other bits read 0, so the defaults of 8 and 8 give 0x00070700.
- R6: Bit 0 of offset 0x6C is the enable bit, and it is 0 after reset. Writing 0 to it empties both queues, so both levels read 0. While the bit is 0, writes to 0x10 are ignored without raising `tx_ovf`, and `eng_cmd_valid` stays low.
- R7: Bit 0 of offset 0x70 follows the `eng_active` input.
- R8: A write to 0x10 while the command queue is full is dropped, the level is unchanged, and `tx_ovf` is high for exactly the one cycle after the write.
- R9: A read of 0x10 while the receive queue is empty returns 0, and `rx_unf` is high for exactly the one cycle after the read.
- R10: `tx_empty` is high exactly when the command queue level is at or below `TX_THRESH`, whose default is 0.
- R11: A read request is accepted only while the queued and outstanding read requests plus the received bytes not yet read total fewer than the receive depth. Otherwise the request is dropped as in R8, while transmit-byte writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| eng_cmd_valid | output | 1 | A command is at the head of the command queue |
| eng_cmd_rd | output | 1 | The head command is a read request |
| eng_cmd_data | output | 8 | Byte to transmit for a write command |
| eng_cmd_take | input | 1 | The engine takes the head command |
| eng_rx_valid | input | 1 | The engine returns one received byte |
| eng_rx_data | input | 8 | The received byte |
| eng_active | input | 1 | The bus is currently busy |
| tx_empty | output | 1 | Command queue at or below the low-water mark |
| tx_ovf | output | 1 | One-cycle pulse: a command write was dropped |
| rx_unf | output | 1 | One-cycle pulse: an empty receive queue was read |

## Verification
Read data is combinational, so the bench samples `bus_rdata` a quarter period after it drives the strobe on the falling edge, before the rising edge that completes the access. A level change, a flush, and the `tx_empty` change that follows a push or take all become visible on that rising edge. The bench reads them back in the next access or one time unit after the edge. The `tx_ovf` and `rx_unf` pulses are registered, so they are checked one time unit after the edge that ended the offending access, and checked low again after the following edge.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam logic [7:0] OFS_DATACMD = 8'h10;
  localparam logic [7:0] OFS_ENABLE  = 8'h6C;
  localparam logic [7:0] OFS_STATUS  = 8'h70;
  localparam logic [7:0] OFS_TXLVL   = 8'h74;
  localparam logic [7:0] OFS_RXLVL   = 8'h78;
  localparam logic [7:0] OFS_PARAM   = 8'hF4;
  localparam int unsigned RD_FLAG_BIT = 8;

  // depth-minus-one word: command depth in 23:16, receive depth in 15:8
  function automatic logic [31:0] depth_word(input int unsigned tx_d,
                                             input int unsigned rx_d);
    logic [7:0] t;
    logic [7:0] r;
    t = 8'(tx_d - 1);
    r = 8'(rx_d - 1);
    return {8'h00, t, r, 8'h00};
  endfunction

  // true while one more read may still reserve a receive slot
  function automatic logic rsv_room(input int unsigned used,
                                    input int unsigned depth);
    return used < depth;
  endfunction

  // low-water test used by the transmit-empty output
  function automatic logic below_mark(input int unsigned lvl,
                                      input int unsigned mark);
    return lvl <= mark;
  endfunction
endpackage

// File: rtl/i2cq_decode.sv
module i2cq_decode
  import i2cq_pkg::*;
(
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  output logic       wr_dc,
  output logic       rd_dc,
  output logic       wr_en
);
  always_comb begin
    wr_dc = bus_sel &&  bus_wr && (bus_addr == OFS_DATACMD);
    rd_dc = bus_sel && !bus_wr && (bus_addr == OFS_DATACMD);
    wr_en = bus_sel &&  bus_wr && (bus_addr == OFS_ENABLE);
  end
endmodule

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      level <= level + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/i2cq_ctrl.sv
module i2cq_ctrl
  import i2cq_pkg::*;
#(
  parameter int unsigned TX_DEPTH  = 8,
  parameter int unsigned RX_DEPTH  = 8,
  parameter int unsigned TX_THRESH = 0,
  localparam int unsigned TCW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        eng_cmd_valid,
  output logic        eng_cmd_rd,
  output logic [7:0]  eng_cmd_data,
  input  logic        eng_cmd_take,
  input  logic        eng_rx_valid,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_active,
  output logic        tx_empty,
  output logic        tx_ovf,
  output logic        rx_unf
);
  // named internal events, also seen by the bound checker
  logic           wr_dc, rd_dc, wr_en;
  logic           en_q, flush;
  logic           req_rd, rsv_ok;
  logic           cmd_accept, ovf_evt, unf_evt, rsv_inc;
  logic           cmd_pop, rx_push, rx_pop_ok;
  logic           cmd_full, cmd_empty, rx_full, rx_empty;
  logic [TCW-1:0] cmd_lvl;
  logic [RCW-1:0] rx_lvl;
  logic [RCW-1:0] res_cnt;
  logic [8:0]     cmd_dout;
  logic [7:0]     rx_dout;
  logic           unused_wbits;

  assign unused_wbits = &{1'b0, bus_wdata[31:9], rx_full};

  i2cq_decode u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_dc   (wr_dc),
    .rd_dc   (rd_dc),
    .wr_en   (wr_en)
  );

  assign flush      = !en_q || (wr_en && !bus_wdata[0]);
  assign req_rd     = bus_wdata[RD_FLAG_BIT];
  assign rsv_ok     = rsv_room(32'(res_cnt), RX_DEPTH);
  assign cmd_accept = wr_dc && en_q && !cmd_full && (!req_rd || rsv_ok);
  assign ovf_evt    = wr_dc && en_q && !cmd_accept;
  assign rsv_inc    = cmd_accept && req_rd;
  assign rx_pop_ok  = rd_dc && !rx_empty;
  assign unf_evt    = rd_dc && rx_empty;
  assign cmd_pop    = eng_cmd_take && en_q;
  assign rx_push    = eng_rx_valid && en_q;

  i2cq_fifo #(.W(9), .DEPTH(TX_DEPTH)) u_cmdq (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(flush),
    .push (cmd_accept),
    .din  ({req_rd, bus_wdata[7:0]}),
    .pop  (cmd_pop),
    .dout (cmd_dout),
    .level(cmd_lvl),
    .full (cmd_full),
    .empty(cmd_empty)
  );

  i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(flush),
    .push (rx_push),
    .din  (eng_rx_data),
    .pop  (rx_pop_ok),
    .dout (rx_dout),
    .level(rx_lvl),
    .full (rx_full),
    .empty(rx_empty)
  );

  assign eng_cmd_valid = en_q && !cmd_empty;
  assign eng_cmd_rd    = cmd_dout[8];
  assign eng_cmd_data  = cmd_dout[7:0];
  assign tx_empty      = below_mark(32'(cmd_lvl), TX_THRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      res_cnt <= '0;
      tx_ovf  <= 1'b0;
      rx_unf  <= 1'b0;
    end else begin
      if (wr_en) en_q <= bus_wdata[0];
      if (flush) res_cnt <= '0;
      else       res_cnt <= res_cnt + RCW'(rsv_inc) - RCW'(rx_pop_ok);
      tx_ovf <= ovf_evt;
      rx_unf <= unf_evt;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_DATACMD: bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_dout};
        OFS_ENABLE:  bus_rdata = {31'h0, en_q};
        OFS_STATUS:  bus_rdata = {31'h0, eng_active};
        OFS_TXLVL:   bus_rdata = 32'(cmd_lvl);
        OFS_RXLVL:   bus_rdata = 32'(rx_lvl);
        OFS_PARAM:   bus_rdata = depth_word(TX_DEPTH, RX_DEPTH);
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_ctrl_chk.sv
module i2cq_ctrl_chk #(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  localparam int unsigned TCW = $clog2(TX_DEPTH + 1),
  localparam int unsigned RCW = $clog2(RX_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_dc,
  input logic           rd_dc,
  input logic           wr_en,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic           en_q,
  input logic           cmd_full,
  input logic [TCW-1:0] cmd_lvl,
  input logic [RCW-1:0] rx_lvl,
  input logic [RCW-1:0] res_cnt,
  input logic           eng_cmd_valid,
  input logic           tx_empty,
  input logic           tx_ovf,
  input logic           rx_unf
);
  a_r8_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dc && en_q && cmd_full) |=> tx_ovf);

  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cmd_lvl) <= TX_DEPTH);

  a_r11_reserve_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(res_cnt) <= RX_DEPTH) && (rx_lvl <= res_cnt));

  a_r9_empty_pop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dc && rx_lvl == '0) |=> rx_unf);

  a_r9_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dc && rx_lvl == '0) |-> (bus_rdata == 32'h0));

  a_r6_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_wdata[0]) |=> (cmd_lvl == '0 && rx_lvl == '0));

  a_r6_idle_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !eng_cmd_valid);

  a_r10_empty_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lvl == '0) |-> tx_empty);
endmodule

bind i2cq_ctrl i2cq_ctrl_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_dc        (wr_dc),
  .rd_dc        (rd_dc),
  .wr_en        (wr_en),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .en_q         (en_q),
  .cmd_full     (cmd_full),
  .cmd_lvl      (cmd_lvl),
  .rx_lvl       (rx_lvl),
  .res_cnt      (res_cnt),
  .eng_cmd_valid(eng_cmd_valid),
  .tx_empty     (tx_empty),
  .tx_ovf       (tx_ovf),
  .rx_unf       (rx_unf)
);

// File: tb/test_i2cq_ctrl.sv
module test_i2cq_ctrl;
  localparam int CLK_P = 10;
  localparam int NV    = 10;
  // {is_write, addr, wdata, expected read}
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h6C, 32'h0,       32'h0},        // R6 enable reads 0 after reset
    {1'b0, 8'hF4, 32'h0,       32'h00070700}, // R5 depth word
    {1'b0, 8'h74, 32'h0,       32'h0},        // R4 reset level
    {1'b1, 8'h6C, 32'h1,       32'h0},
    {1'b0, 8'h6C, 32'h0,       32'h1},        // R6 enable readback
    {1'b1, 8'h10, 32'h0A5,     32'h0},        // R1 byte
    {1'b1, 8'h10, 32'hFFFFFE5A, 32'h0},       // R1 byte, bit 8 clear, upper junk
    {1'b1, 8'h10, 32'h100,     32'h0},        // R2 read request
    {1'b0, 8'h74, 32'h0,       32'h3},        // R4 command level
    {1'b0, 8'h78, 32'h0,       32'h0}         // R4 receive level
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_cmd_valid, eng_cmd_rd;
  logic [7:0]  eng_cmd_data;
  logic        eng_cmd_take = 1'b0;
  logic        eng_rx_valid = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_active = 1'b0;
  logic        tx_empty, tx_ovf, rx_unf;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  i2cq_ctrl i_i2cq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_rd(eng_cmd_rd),
    .eng_cmd_data(eng_cmd_data), .eng_cmd_take(eng_cmd_take),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .eng_active(eng_active),
    .tx_empty(tx_empty), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
  );

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", msg, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #(CLK_P/4);
    r = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_wr_op(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus_op(1'b1, a, d, dummy);
  endtask

  task automatic bus_rd_chk(input logic [7:0] a, input logic [31:0] exp, input string msg);
    logic [31:0] r;
    bus_op(1'b0, a, 32'h0, r);
    chk(msg, r, exp);
  endtask

  task automatic eng_take(input logic rd, input logic [7:0] d, input string msg);
    @(negedge clk);
    chk({msg, " valid"}, 32'(eng_cmd_valid), 32'h1);
    chk({msg, " kind"}, 32'(eng_cmd_rd), 32'(rd));
    if (!rd) chk({msg, " byte"}, 32'(eng_cmd_data), 32'(d));
    eng_cmd_take = 1'b1;
    @(posedge clk);
    #1;
    eng_cmd_take = 1'b0;
  endtask

  task automatic eng_give(input logic [7:0] d);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = d;
    @(posedge clk);
    #1;
    eng_rx_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk("R6 no command offered after reset", 32'(eng_cmd_valid), 32'h0);
    chk("R10 tx_empty after reset", 32'(tx_empty), 32'h1);
    chk("R8 tx_ovf low after reset", 32'(tx_ovf), 32'h0);
    chk("R9 rx_unf low after reset", 32'(rx_unf), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][72], VEC[i][71:64], VEC[i][63:32], r);
      if (!VEC[i][72]) chk($sformatf("R4/R5/R6 vector %0d", i), r, VEC[i][31:0]);
    end

    chk("R10 tx_empty low with 3 queued", 32'(tx_empty), 32'h0);
    eng_take(1'b0, 8'hA5, "R1 first byte");
    eng_take(1'b0, 8'h5A, "R1 second byte upper bits ignored");
    eng_take(1'b1, 8'h00, "R2 read request");
    chk("R10 tx_empty after drain", 32'(tx_empty), 32'h1);

    eng_give(8'h77);
    bus_rd_chk(8'h78, 32'h1, "R4 rx level after push");
    bus_rd_chk(8'h10, 32'h77, "R3 pop received byte");
    chk("R9 no underflow on valid pop", 32'(rx_unf), 32'h0);
    bus_rd_chk(8'h78, 32'h0, "R3 rx level after pop");

    bus_rd_chk(8'h10, 32'h0, "R9 empty pop returns zero");
    chk("R9 rx_unf pulse", 32'(rx_unf), 32'h1);
    @(posedge clk); #1;
    chk("R9 rx_unf one cycle", 32'(rx_unf), 32'h0);

    // R8: fill the command queue, then overflow
    for (int i = 0; i < 8; i++) bus_wr_op(8'h10, 32'(8'h20 + i));
    bus_rd_chk(8'h74, 32'h8, "R8 level full");
    bus_wr_op(8'h10, 32'h0EE);
    chk("R8 tx_ovf pulse", 32'(tx_ovf), 32'h1);
    bus_rd_chk(8'h74, 32'h8, "R8 level unchanged");
    chk("R8 tx_ovf one cycle", 32'(tx_ovf), 32'h0);
    for (int i = 0; i < 8; i++) eng_take(1'b0, 8'(8'h20 + i), $sformatf("R1 order %0d", i));

    // R11: reservation limit on read requests
    for (int i = 0; i < 5; i++) bus_wr_op(8'h10, 32'h100);
    for (int i = 0; i < 5; i++) eng_take(1'b1, 8'h00, "R11 issued read");
    for (int i = 0; i < 5; i++) eng_give(8'(8'h30 + i));
    bus_rd_chk(8'h78, 32'h5, "R11 rx level 5");
    for (int i = 0; i < 3; i++) bus_wr_op(8'h10, 32'h100);
    chk("R11 reads within limit accepted", 32'(tx_ovf), 32'h0);
    bus_wr_op(8'h10, 32'h100);
    chk("R11 read beyond reservation dropped", 32'(tx_ovf), 32'h1);
    bus_wr_op(8'h10, 32'h044);
    chk("R11 byte write still accepted", 32'(tx_ovf), 32'h0);
    bus_rd_chk(8'h74, 32'h4, "R11 command level");
    bus_rd_chk(8'h10, 32'h30, "R3 oldest of several");

    // R6: disable flushes and blocks
    bus_wr_op(8'h6C, 32'h0);
    bus_rd_chk(8'h74, 32'h0, "R6 command level flushed");
    bus_rd_chk(8'h78, 32'h0, "R6 rx level flushed");
    bus_wr_op(8'h10, 32'h011);
    chk("R6 disabled write no overflow", 32'(tx_ovf), 32'h0);
    bus_rd_chk(8'h74, 32'h0, "R6 disabled write ignored");
    chk("R6 no command while disabled", 32'(eng_cmd_valid), 32'h0);
    bus_rd_chk(8'h6C, 32'h0, "R6 enable readback 0");
    bus_wr_op(8'h6C, 32'h1);
    bus_rd_chk(8'h10, 32'h0, "R6 stale bytes gone");

    // R7: status mirrors bus activity
    eng_active = 1'b1;
    bus_rd_chk(8'h70, 32'h1, "R7 active");
    eng_active = 1'b0;
    bus_rd_chk(8'h70, 32'h0, "R7 idle");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule